// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block shares a small bank of port pins among a fixed list of peripheral signal groups. Each group is a set of signals that must be placed together, such as a serial transmitter and receiver. Three 8-bit configuration registers hold the group enables and two global controls. From those registers the block decides which pin carries which peripheral signal. Enabled groups are placed in a fixed priority order. Each one takes the next run of free digital pins, counting up from pin 0 of the lowest port. Pins that are configured as analog are passed over. Any pin that no group claims stays a general-purpose pin and is driven from its GPIO latch.

The placement is recomputed combinationally whenever the registers or the pin input modes change. A group that no longer fits in the remaining digital pins is left off the pins and an overflow flag is raised. Lower-priority groups that still fit keep being placed. Every output enable is held low until the global crossbar enable is set. A second global bit turns off all weak pull-ups. Peripheral inputs are routed back from the pins that carry them. A signal with no pin reads as logic 1. The peripherals and the pad drivers sit outside this block.

Top module: `pxbar_top`

## Requirements
- R1: After a synchronous active-low reset all three configuration registers read as zero, so no pin is selected, every output enable is low, every peripheral input reads 1 and the overflow flag is low.
- R2: Enabled groups are placed in priority order 0 to 5, each on consecutive free digital pins. Placement starts at pin 0, where pin index = port * 8 + bit, and each group begins after the last pin used by the previous placed group. Signal k of a group lands on that group's k-th pin.
- R3: Group table, listed as name: enable bit, signal count, output signals (the rest are inputs). Group 0 is uart-a: reg 0 bit 2, 2 signals, output signal 0. Group 1 is serial-peripheral: reg 0 bit 1, 4 signals, outputs 0 and 2. Group 2 is two-wire: reg 0 bit 0, 2 signals, both outputs. Group 3 is uart-b: reg 2 bit 2, 2 signals, output 0. Group 4 is capture: reg 1 bit 0, 2 signals, no outputs. Group 5 is conversion-start: reg 2 bit 0, 1 signal, no outputs. No other register bit enables a group. The flat peripheral vectors hold the groups in this order, with offsets 0, 2, 6, 8, 10 and 12.
- R4: With uart-a enabled and pins 0 and 1 digital, its transmit signal is on pin 0 and its receive signal is on pin 1, whatever other groups are enabled.
- R5: While reg 2 bit 6 (crossbar enable) is 0, every pin output enable is 0 and every peripheral input reads 1.
- R6: A pin's weak pull-up is on exactly when reg 2 bit 7 is 0, the pin is digital, and the pin is not driving a 0 (output enable high with output 0).
- R7: A pin whose pin_digital bit is 0 is never selected and never has its output enable set. Later groups move past it to the next digital pins.
- R8: A pin that is not selected drives its GPIO latch bit. Its output enable equals the crossbar enable for a digital pin and 0 for an analog pin.
- R9: An enabled group that does not fit in the digital pins left after the higher-priority placements is not placed, and lower-priority groups are still tried. alloc_ovf is 1 exactly when some enabled group is not placed.
- R10: A selected pin drives the peripheral output signal it carries. Its output enable is 1 only when the crossbar is enabled and that signal is an output in the R3 table.
- R11: Every signal of a placed group reads its pin's input while the crossbar is enabled. A signal with no pin reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Register select (0, 1, 2) |
| cfg_wdata | input | 8 | Register write data |
| pin_digital | input | NUM_PORTS*PORT_W | Per-pin input mode, 1 = digital, 0 = analog |
| gpio_out | input | NUM_PORTS*PORT_W | GPIO latch values |
| pin_in | input | NUM_PORTS*PORT_W | Levels sensed at the pins |
| per_out | input | 13 | Peripheral output signals, flat in group order |
| per_in | output | 13 | Peripheral input signals, flat in group order |
| pin_out | output | NUM_PORTS*PORT_W | Per-pin output value |
| pin_oe | output | NUM_PORTS*PORT_W | Per-pin output enable |
| pin_sel | output | NUM_PORTS*PORT_W | 1 where a pin carries a peripheral signal |
| pin_pu_en | output | NUM_PORTS*PORT_W | Per-pin weak pull-up enable |
| alloc_ovf | output | 1 | Some enabled group could not be placed |

## Verification
A wrong digital rank or a wrong group start shows up at once as a shifted pin_sel pattern. The same fault sends peripheral outputs to the wrong pin_out bits in the same cycle that the registers or the pin modes change, because placement has no pipeline. A corrupted configuration register shows one clock after the write, as a missing or extra group, a wrong overflow flag, or output enables that ignore the crossbar enable. The sweep covers every mix of group enables against several analog patterns. A fault that only matters when pins run short or when analog pins sit inside a group's run is therefore still driven to the ports.

// File: rtl/pxbar_pkg.sv
// Shared constants for the pin crossbar: register layout and group table.
// Assumes groups are listed in priority order, highest first.
package pxbar_pkg;
    localparam int CFG_W       = 8;
    localparam int NCFG        = 3;
    localparam int CFG_BITS    = CFG_W * NCFG;
    localparam int CFG_AW      = $clog2(NCFG);
    localparam int XBAR_EN_BIT = 2 * CFG_W + 6;
    localparam int PU_DIS_BIT  = 2 * CFG_W + 7;

    localparam int NGRP = 6;
    typedef int grp_tab_t [NGRP];
    // signals per group
    localparam grp_tab_t GRP_CNT   = '{2, 4, 2, 2, 2, 1};
    // enable bit position inside the concatenated registers
    localparam grp_tab_t GRP_ENBIT = '{2, 1, 0, 2 * CFG_W + 2, CFG_W, 2 * CFG_W};
    // bit k set: signal k of the group is an output
    localparam grp_tab_t GRP_OMASK = '{1, 5, 3, 1, 0, 0};

    // Offset of group g inside the flat peripheral vectors.
    function automatic int grp_ofs(input int g);
        int s;
        s = 0;
        for (int i = 0; i < NGRP; i++) begin
            if (i < g) s += GRP_CNT[i];
        end
        return s;
    endfunction

    localparam int NSIG = grp_ofs(NGRP);
    localparam int SW   = $clog2(NSIG);
endpackage

// File: rtl/pxbar_cfg_regs.sv
// Three 8-bit configuration registers, written one at a time.
// Assumes a write to an address with no register is dropped.
module pxbar_cfg_regs
    import pxbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CFG_AW-1:0]   addr,
    input  logic [CFG_W-1:0]    wdata,
    output logic [CFG_BITS-1:0] cfg_flat
);
    for (genvar r = 0; r < NCFG; r++) begin : g_reg
        logic [CFG_W-1:0] q;

        // hold or update one register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && addr == CFG_AW'(r)) begin
                q <= wdata;
            end
        end

        assign cfg_flat[r*CFG_W +: CFG_W] = q;
    end
endmodule

// File: rtl/pxbar_rank.sv
// Numbers the digital pins: rank[p] counts the digital pins below p.
// Analog pins get the rank of the next digital pin but are never used.
module pxbar_rank #(
    parameter int NPIN = 16,
    parameter int RW   = 5
) (
    input  logic [NPIN-1:0]         pin_digital,
    output logic [NPIN-1:0][RW-1:0] rank,
    output logic [RW-1:0]           ndig
);
    // running prefix count of digital pins
    always_comb begin
        logic [RW-1:0] acc;
        acc = '0;
        for (int p = 0; p < NPIN; p++) begin
            rank[p] = acc;
            acc     = acc + RW'(pin_digital[p]);
        end
        ndig = acc;
    end
endmodule

// File: rtl/pxbar_alloc.sv
// Places enabled groups in priority order on the digital-rank axis.
// A group that does not fit is skipped; the cursor does not advance.
module pxbar_alloc
    import pxbar_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [NGRP-1:0]         grp_en,
    input  logic [RW-1:0]           ndig,
    output logic [NGRP-1:0]         grp_map,
    output logic [NGRP-1:0][RW-1:0] grp_start,
    output logic                    ovf
);
    // walk the groups, keep a cursor of used digital ranks
    always_comb begin
        int cur;
        cur = 0;
        ovf = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            grp_start[g] = RW'(cur);
            grp_map[g]   = 1'b0;
            if (grp_en[g]) begin
                if (cur + GRP_CNT[g] <= int'(ndig)) begin
                    grp_map[g] = 1'b1;
                    cur        = cur + GRP_CNT[g];
                end else begin
                    ovf = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pxbar_route.sv
// Per-pin muxing: finds the owning group of each pin and steers
// outputs, enables, pull-ups and peripheral inputs.
// Assumes grp_start/grp_map come from pxbar_alloc on the same ranks.
module pxbar_route
    import pxbar_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int RW   = 5
) (
    input  logic [NPIN-1:0]         pin_digital,
    input  logic [NPIN-1:0][RW-1:0] rank,
    input  logic [NGRP-1:0]         grp_map,
    input  logic [NGRP-1:0][RW-1:0] grp_start,
    input  logic                    xbar_en,
    input  logic                    pu_dis,
    input  logic [NPIN-1:0]         gpio_out,
    input  logic [NPIN-1:0]         pin_in,
    input  logic [NSIG-1:0]         per_out,
    output logic [NSIG-1:0]         per_in,
    output logic [NPIN-1:0]         pin_out,
    output logic [NPIN-1:0]         pin_oe,
    output logic [NPIN-1:0]         pin_sel,
    output logic [NPIN-1:0]         pin_pu_en
);
    logic [NPIN-1:0][SW-1:0] sig_w;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic          sel_l;
        logic          dir_l;
        logic [SW-1:0] sig_l;

        // look up which group, and which of its signals, owns this pin
        always_comb begin
            int off;
            sel_l = 1'b0;
            dir_l = 1'b0;
            sig_l = '0;
            for (int g = 0; g < NGRP; g++) begin
                off = int'(rank[p]) - int'(grp_start[g]);
                if (pin_digital[p] && grp_map[g] && off >= 0 && off < GRP_CNT[g]) begin
                    sel_l = 1'b1;
                    dir_l = ((GRP_OMASK[g] >> off) & 1) != 0;
                    sig_l = SW'(grp_ofs(g) + off);
                end
            end
        end

        assign pin_sel[p]   = sel_l;
        assign sig_w[p]     = sig_l;
        assign pin_out[p]   = sel_l ? per_out[sig_l] : gpio_out[p];
        assign pin_oe[p]    = xbar_en & (sel_l ? dir_l : pin_digital[p]);
        assign pin_pu_en[p] = ~pu_dis & pin_digital[p] & ~(pin_oe[p] & ~pin_out[p]);
    end

    // return pin levels to the signals that own a pin; idle high otherwise
    always_comb begin
        per_in = '1;
        for (int p = 0; p < NPIN; p++) begin
            if (xbar_en && pin_sel[p]) per_in[sig_w[p]] = pin_in[p];
        end
    end
endmodule

// File: rtl/pxbar_top.sv
// Priority crossbar top: registers, digital ranking, group placement
// and per-pin routing. All placement logic is combinational.
module pxbar_top
    import pxbar_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [CFG_W-1:0]            cfg_wdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_digital,
    input  logic [NUM_PORTS*PORT_W-1:0] gpio_out,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    input  logic [NSIG-1:0]             per_out,
    output logic [NSIG-1:0]             per_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pin_sel,
    output logic [NUM_PORTS*PORT_W-1:0] pin_pu_en,
    output logic                        alloc_ovf
);
    localparam int NPIN = NUM_PORTS * PORT_W;
    localparam int RW   = $clog2(NPIN + 1);

    logic [CFG_BITS-1:0]     cfg_flat;
    logic [NGRP-1:0]         grp_en;
    logic [NGRP-1:0]         grp_map;
    logic [NGRP-1:0][RW-1:0] grp_start;
    logic [NPIN-1:0][RW-1:0] rank;
    logic [RW-1:0]           ndig;
    logic                    unused_cfg;

    assign unused_cfg = ^cfg_flat;

    pxbar_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg_flat (cfg_flat)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_en
        assign grp_en[g] = cfg_flat[GRP_ENBIT[g]];
    end

    pxbar_rank #(.NPIN(NPIN), .RW(RW)) u_rank (
        .pin_digital (pin_digital),
        .rank        (rank),
        .ndig        (ndig)
    );

    pxbar_alloc #(.RW(RW)) u_alloc (
        .grp_en    (grp_en),
        .ndig      (ndig),
        .grp_map   (grp_map),
        .grp_start (grp_start),
        .ovf       (alloc_ovf)
    );

    pxbar_route #(.NPIN(NPIN), .RW(RW)) u_route (
        .pin_digital (pin_digital),
        .rank        (rank),
        .grp_map     (grp_map),
        .grp_start   (grp_start),
        .xbar_en     (cfg_flat[XBAR_EN_BIT]),
        .pu_dis      (cfg_flat[PU_DIS_BIT]),
        .gpio_out    (gpio_out),
        .pin_in      (pin_in),
        .per_out     (per_out),
        .per_in      (per_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_sel     (pin_sel),
        .pin_pu_en   (pin_pu_en)
    );
endmodule

// File: rtl/pxbar_chk.sv
// Property checker for pxbar_top, attached by bind below.
module pxbar_chk
    import pxbar_pkg::*;
#(
    parameter int NPIN = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CFG_BITS-1:0] cfg_flat,
    input logic [NPIN-1:0]     pin_digital,
    input logic [NPIN-1:0]     pin_sel,
    input logic [NPIN-1:0]     pin_oe,
    input logic [NPIN-1:0]     pin_pu_en,
    input logic [NSIG-1:0]     per_in,
    input logic                alloc_ovf
);
    int   need;
    logic unused_bits;

    assign unused_bits = ^cfg_flat;

    // pins requested by the enabled groups
    always_comb begin
        need = 0;
        for (int g = 0; g < NGRP; g++) begin
            if (cfg_flat[GRP_ENBIT[g]]) need += GRP_CNT[g];
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_sel == '0 && pin_oe == '0 && !alloc_ovf));

    p_pin_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_sel) <= $countones(pin_digital));

    p_oe_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flat[XBAR_EN_BIT] |-> (pin_oe == '0 && per_in == '1));

    p_pullup_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flat[PU_DIS_BIT] |-> pin_pu_en == '0);

    p_analog_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_sel | pin_oe) & ~pin_digital) == '0);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ovf |-> $countones(pin_sel) == need);

    p_overflow_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ovf |-> $countones(pin_sel) < need);
endmodule

bind pxbar_top pxbar_chk #(.NPIN(NUM_PORTS * PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_flat    (cfg_flat),
    .pin_digital (pin_digital),
    .pin_sel     (pin_sel),
    .pin_oe      (pin_oe),
    .pin_pu_en   (pin_pu_en),
    .per_in      (per_in),
    .alloc_ovf   (alloc_ovf)
);

// File: tb/pxbar_top_tb_top.sv
`timescale 1ns/1ps
// Sweeps every group-enable mix against several analog patterns and
// compares all outputs with a pin-walking reference model.
module pxbar_top_tb_top;
    localparam int NPIN = 16;
    localparam int NSIG = 13;
    localparam int NG   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [NPIN-1:0] pin_digital = '1;
    logic [NPIN-1:0] gpio_out = '0;
    logic [NPIN-1:0] pin_in = '0;
    logic [NSIG-1:0] per_out = '0;
    logic [NSIG-1:0] per_in;
    logic [NPIN-1:0] pin_out, pin_oe, pin_sel, pin_pu_en;
    logic            alloc_ovf;

    int checks = 0;
    int errors = 0;
    int b_cnt [NG] = '{2, 4, 2, 2, 2, 1};
    int b_om  [NG] = '{1, 5, 3, 1, 0, 0};

    logic [NPIN-1:0] e_sel, e_oe, e_out, e_pu, e_dir;
    logic [NSIG-1:0] e_in;
    logic            e_ovf;
    int              e_sig [NPIN];
    logic [31:0]     rng = 32'h1234_5678;

    always #5 clk = ~clk;

    pxbar_top dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .pin_digital (pin_digital), .gpio_out (gpio_out),
        .pin_in (pin_in), .per_out (per_out), .per_in (per_in), .pin_out (pin_out),
        .pin_oe (pin_oe), .pin_sel (pin_sel), .pin_pu_en (pin_pu_en),
        .alloc_ovf (alloc_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    // reference: walk the pins with a cursor, one group at a time
    task automatic model(input logic [NG-1:0] en, input logic xen, input logic pud);
        int cursor, ofs;
        cursor = 0; ofs = 0;
        e_sel = '0; e_dir = '0; e_ovf = 1'b0; e_in = '1;
        for (int p = 0; p < NPIN; p++) e_sig[p] = 0;
        for (int g = 0; g < NG; g++) begin
            if (en[g]) begin
                int q, got;
                int lst [4];
                q = cursor; got = 0;
                for (int k = 0; k < 4; k++) lst[k] = 0;
                while (q < NPIN && got < b_cnt[g]) begin
                    if (pin_digital[q]) begin lst[got] = q; got++; end
                    q++;
                end
                if (got == b_cnt[g]) begin
                    for (int k = 0; k < got; k++) begin
                        e_sel[lst[k]] = 1'b1;
                        e_sig[lst[k]] = ofs + k;
                        e_dir[lst[k]] = ((b_om[g] >> k) & 1) != 0;
                    end
                    cursor = q;
                end else begin
                    e_ovf = 1'b1;
                end
            end
            ofs += b_cnt[g];
        end
        for (int p = 0; p < NPIN; p++) begin
            e_out[p] = e_sel[p] ? per_out[e_sig[p]] : gpio_out[p];
            e_oe[p]  = xen && (e_sel[p] ? e_dir[p] : pin_digital[p]);
            e_pu[p]  = !pud && pin_digital[p] && !(e_oe[p] && !e_out[p]);
            if (xen && e_sel[p]) e_in[e_sig[p]] = pin_in[p];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] amask [8];
        amask = '{16'h0000, 16'h0001, 16'h00F0, 16'hAAAA,
                  16'hFF00, 16'h7FFE, 16'hFFFF, 16'h0C03};
        gpio_out = 16'hA55A;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 sel after reset", 32'(pin_sel), 32'h0);
        check("R1 oe after reset", 32'(pin_oe), 32'h0);
        check("R1 ovf after reset", 32'(alloc_ovf), 32'h0);
        check("R1 per_in after reset", 32'(per_in), 32'h1FFF);
        check("R8 gpio after reset", 32'(pin_out), 32'hA55A);

        // R3: bits outside the group table enable nothing
        wr(2'd0, 8'hF8); wr(2'd1, 8'hFE); wr(2'd2, 8'h7A); #1;
        check("R3 stray bits sel", 32'(pin_sel), 32'h0);
        check("R3 stray bits ovf", 32'(alloc_ovf), 32'h0);

        // R4: uart-a alone, then with every other group
        per_out = 13'h1FFE; pin_in = 16'h0002;
        wr(2'd0, 8'h04); wr(2'd1, 8'h00); wr(2'd2, 8'h40); #1;
        check("R4 uart-a pins", 32'(pin_sel), 32'h0003);
        check("R4 tx oe", 32'(pin_oe[1:0]), 32'h1);
        check("R4 tx drives pin0", 32'(pin_out[0]), 32'h0);
        check("R4 rx from pin1", 32'(per_in[1]), 32'h1);
        wr(2'd0, 8'h07); wr(2'd1, 8'h01); wr(2'd2, 8'h45); #1;
        check("R4 uart-a first with all groups", 32'(pin_sel[1:0]), 32'h3);

        for (int mi = 0; mi < 8; mi++) begin
            for (int e = 0; e < 64; e++) begin
                int n;
                logic xen, pud;
                logic [5:0] en;
                n = mi * 64 + e;
                en = 6'(e);
                xen = (n % 5) != 4;
                pud = (n % 3) == 0;
                wr(2'd0, {5'b0, en[0], en[1], en[2]});
                wr(2'd1, {7'b0, en[4]});
                wr(2'd2, {pud, xen, 3'b0, en[3], 1'b0, en[5]});
                pin_digital = ~amask[mi];
                rng = nxt(rng); per_out  = rng[12:0];
                rng = nxt(rng); gpio_out = rng[15:0];
                rng = nxt(rng); pin_in   = rng[15:0];
                #1;
                model(en, xen, pud);
                check("R2 R3 R7 R9 placement", 32'(pin_sel), 32'(e_sel));
                check("R5 R8 R10 output enable", 32'(pin_oe), 32'(e_oe));
                check("R8 R10 pin output", 32'(pin_out), 32'(e_out));
                check("R6 pull-ups", 32'(pin_pu_en), 32'(e_pu));
                check("R9 overflow", 32'(alloc_ovf), 32'(e_ovf));
                check("R5 R11 peripheral inputs", 32'(per_in), 32'(e_in));
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule